// File: doc/BRIEF.md
# PLL Lock Supervisor and Output Gate

This block sequences a phase-locked loop once it is enabled. It decides when the loop's output clock may be released to the rest of the chip. A 32-bit control word holds the loop's settings. Most fields (divider, filter choices, reference choice) are only stored for the analog side. Three fields steer the sequencer:
- a 3-bit lock-time code,
- a fast-wake bit,
- a lock-bypass bit.

After enable, the sequencer waits for a one-cycle startup-done pulse. It then either releases the output at once (fast wake) or waits for lock. A microsecond tick paces an optional lock time-out, which parks the sequencer in a time-out state and raises a sticky flag.

The control word accepts bus writes only while the loop is disabled. This keeps the settings stable for the whole time the loop runs.

Top module: `pll_lock_supervisor`

## Requirements
- R1: After reset the control word reads 0x00000020, `out_en` and `lock_timeout` are 0, and `status` is 0x00.
- R2: A write with `loop_en` low stores `wr_data` with bits 31:27 forced to zero. The fields are packed as follows: lock time in bits 10:8, lock bypass in bit 11, fast wake in bit 4; the other bits are stored as written.
- R3: A write while `loop_en` is high leaves the control word unchanged.
- R4: A written lock-time code of 1, 2 or 3 is stored as 0.
- R5: With `loop_en` high, the state moves from IDLE to STARTUP one cycle later. If fast wake is 0, a startup-done pulse moves the state to WAIT_LOCK, and `out_en` rises in the cycle after lock is seen there.
- R6: With fast wake set to 1, `out_en` rises one cycle after the startup-done pulse, whatever the lock input is.
- R7: With lock-time code 0, no time-out ever occurs and the state stays in WAIT_LOCK until lock.
- R8: With codes 4 to 7, the limit is 800, 900, 1000 or 1100 ticks in WAIT_LOCK. If no lock is seen within that many ticks, the state becomes TIMEOUT at the edge of the last tick, with `out_en` low and `lock_timeout` set.
- R9: The tick count restarts from zero on every entry to WAIT_LOCK.
- R10: `lock_timeout` stays set until a `to_clr` pulse. A new time-out in the same cycle as a clear wins.
- R11: With `loop_en` low, the state is IDLE in the next cycle and `out_en` is 0.
- R12: With lock bypass set, the lock input is taken as asserted.
- R13: `status` is laid out as follows:
  - bits 2:0 hold the state code (IDLE=0, STARTUP=1, WAIT_LOCK=2, RUN=3, TIMEOUT=4);
  - bit 3 is the effective lock;
  - bit 4 is the time-out flag;
  - bit 5 is `out_en`;
  - bits 7:6 are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| loop_en | input | 1 | Loop enable; also blocks control writes |
| wr_en | input | 1 | Control-word write strobe |
| wr_data | input | 32 | Control-word write data |
| to_clr | input | 1 | Clears the sticky time-out flag |
| tick_us | input | 1 | One-cycle pulse every microsecond |
| startup_done | input | 1 | One-cycle pulse when loop startup completes |
| lock_in | input | 1 | Lock indication from the loop |
| ctrl_rd | output | 32 | Current control word |
| out_en | output | 1 | Output clock gate enable |
| lock_timeout | output | 1 | Sticky lock time-out flag |
| status | output | 8 | State code, effective lock, flag, gate |

## Verification
A wrong state code shows on `status` bits 2:0 in the very cycle after the bad transition. A wrong `out_en` shows at the same edge, because `out_en` is decoded straight from the state. A tick counter that is off by one, or that fails to restart, shows only at the edge where a time-out should or should not occur. That edge can be up to 1100 ticks after startup, so the limits are probed one tick before and at the exact tick. A corrupted stored field shows on `ctrl_rd` at the next edge after the write.

// File: rtl/pls_pkg.sv
package pls_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_STARTUP = 3'd1,
        ST_WAIT    = 3'd2,
        ST_RUN     = 3'd3,
        ST_TIMEOUT = 3'd4
    } pls_state_e;

    typedef struct packed {
        logic [4:0]  rsvd;
        logic [10:0] div;
        logic        filt_ctl_en;
        logic [2:0]  dco_sel;
        logic        lock_bypass;
        logic [2:0]  lock_time;
        logic [2:0]  ref_sel;
        logic        fast_wake;
        logic [3:0]  pi_sel;
    } pls_ctrl_t;

    localparam int CTRL_W = 32;
    localparam logic [31:0] CTRL_RESET = 32'h0000_0020;

endpackage

// File: rtl/pls_ctrl_reg.sv
module pls_ctrl_reg
    import pls_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              loop_en,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output pls_ctrl_t         ctrl
);

    typedef struct packed {
        pls_ctrl_t word;
    } reg_s;

    reg_s r_d, r_q;
    pls_ctrl_t incoming;

    always_comb begin
        incoming = pls_ctrl_t'(wr_data);
        incoming.rsvd = '0;
        // reserved lock-time codes fold onto "no time-out"
        if (incoming.lock_time[2] == 1'b0) begin
            incoming.lock_time = 3'd0;
        end
        r_d = r_q;
        if (wr_en && !loop_en) begin
            r_d.word = incoming;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.word <= pls_ctrl_t'(CTRL_RESET);
        end else begin
            r_q <= r_d;
        end
    end

    assign ctrl = r_q.word;

    AST_WRITE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        loop_en |=> (ctrl == $past(ctrl))); // R3
    AST_RSVD_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctrl.lock_time inside {3'd1, 3'd2, 3'd3})); // R4
    AST_TOP_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !loop_en) |=> (ctrl.rsvd == 5'd0)); // R2

endmodule

// File: rtl/pls_lock_timer.sv
module pls_lock_timer #(
    parameter int TO_BASE = 800,
    parameter int TO_STEP = 100
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic       run,
    input  logic       tick,
    input  logic [2:0] code,
    output logic       expire
);

    localparam int MAX_LIM = TO_BASE + 3 * TO_STEP;
    localparam int CNT_W   = $clog2(MAX_LIM + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_s;

    tmr_s t_d, t_q;
    logic [CNT_W-1:0] lim;
    logic             armed;

    always_comb begin
        armed = code[2];
        lim   = CNT_W'(TO_BASE + TO_STEP * int'(code[1:0]));
        expire = run && tick && armed && (t_q.cnt == lim - 1'b1);
        t_d = t_q;
        if (restart) begin
            t_d.cnt = '0;
        end else if (run && tick && !expire) begin
            t_d.cnt = t_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q.cnt <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    AST_CNT_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (run && armed) |-> (t_q.cnt < lim)); // R8
    AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (t_q.cnt == '0)); // R9

endmodule

// File: rtl/pls_seq.sv
module pls_seq
    import pls_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       loop_en,
    input  logic       startup_done,
    input  logic       lock_eff,
    input  logic       fast_wake,
    input  logic [2:0] lock_time,
    input  logic       expire,
    input  logic       to_clr,
    output pls_state_e state,
    output logic       enter_wait,
    output logic       to_flag,
    output logic       out_en
);

    typedef struct packed {
        pls_state_e st;
        logic       flag;
    } seq_s;

    seq_s s_d, s_q;

    always_comb begin
        s_d        = s_q;
        enter_wait = 1'b0;
        if (to_clr) begin
            s_d.flag = 1'b0;
        end
        if (!loop_en) begin
            s_d.st = ST_IDLE;
        end else begin
            unique case (s_q.st)
                ST_IDLE: s_d.st = ST_STARTUP;
                ST_STARTUP: begin
                    if (startup_done) begin
                        if (fast_wake) begin
                            s_d.st = ST_RUN;
                        end else begin
                            s_d.st     = ST_WAIT;
                            enter_wait = 1'b1;
                        end
                    end
                end
                ST_WAIT: begin
                    if (lock_eff) begin
                        s_d.st = ST_RUN;
                    end else if (expire) begin
                        s_d.st   = ST_TIMEOUT;
                        s_d.flag = 1'b1;
                    end
                end
                ST_RUN:     s_d.st = ST_RUN;
                ST_TIMEOUT: s_d.st = ST_TIMEOUT;
                default:    s_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st   <= ST_IDLE;
            s_q.flag <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign state   = s_q.st;
    assign to_flag = s_q.flag;
    assign out_en  = (s_q.st == ST_RUN);

    AST_DISABLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !loop_en |=> (state == ST_IDLE)); // R11
    AST_GATE_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(out_en) && !fast_wake) |-> $past(lock_eff)); // R5
    AST_NO_TIMEOUT_CODE0: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_time == 3'd0) |-> (state != ST_TIMEOUT)); // R7
    AST_TIMEOUT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TIMEOUT && $past(state) != ST_TIMEOUT) |-> to_flag); // R10
    AST_TIMEOUT_GATE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TIMEOUT) |-> !out_en); // R8

endmodule

// File: rtl/pll_lock_supervisor.sv
module pll_lock_supervisor
    import pls_pkg::*;
#(
    parameter int TO_BASE = 800,
    parameter int TO_STEP = 100,
    parameter int STAT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              loop_en,
    input  logic              wr_en,
    input  logic [31:0]       wr_data,
    input  logic              to_clr,
    input  logic              tick_us,
    input  logic              startup_done,
    input  logic              lock_in,
    output logic [31:0]       ctrl_rd,
    output logic              out_en,
    output logic              lock_timeout,
    output logic [STAT_W-1:0] status
);

    pls_ctrl_t  ctrl;
    pls_state_e state;
    logic       enter_wait;
    logic       expire;
    logic       lock_eff;
    logic       wait_run;

    pls_ctrl_reg i_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .loop_en (loop_en),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .ctrl    (ctrl)
    );

    assign lock_eff = lock_in || ctrl.lock_bypass;
    assign wait_run = (state == ST_WAIT);

    pls_lock_timer #(
        .TO_BASE (TO_BASE),
        .TO_STEP (TO_STEP)
    ) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (enter_wait),
        .run     (wait_run),
        .tick    (tick_us),
        .code    (ctrl.lock_time),
        .expire  (expire)
    );

    pls_seq i_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .loop_en      (loop_en),
        .startup_done (startup_done),
        .lock_eff     (lock_eff),
        .fast_wake    (ctrl.fast_wake),
        .lock_time    (ctrl.lock_time),
        .expire       (expire),
        .to_clr       (to_clr),
        .state        (state),
        .enter_wait   (enter_wait),
        .to_flag      (lock_timeout),
        .out_en       (out_en)
    );

    assign ctrl_rd = ctrl;

    always_comb begin
        status      = '0;
        status[2:0] = state;
        status[3]   = lock_eff;
        status[4]   = lock_timeout;
        status[5]   = out_en;
    end

    AST_FAST_WAKE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_en && state == ST_STARTUP && startup_done && ctrl.fast_wake) |=> out_en); // R6
    AST_BYPASS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.lock_bypass |-> status[3]); // R12

endmodule

// File: tb/test_pll_lock_supervisor.sv
module test_pll_lock_supervisor;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        loop_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        to_clr = 1'b0;
    logic        tick_us = 1'b0;
    logic        startup_done = 1'b0;
    logic        lock_in = 1'b0;
    logic [31:0] ctrl_rd;
    logic        out_en;
    logic        lock_timeout;
    logic [7:0]  status;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pll_lock_supervisor i_pll_lock_supervisor (
        .clk          (clk),
        .rst_n        (rst_n),
        .loop_en      (loop_en),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .to_clr       (to_clr),
        .tick_us      (tick_us),
        .startup_done (startup_done),
        .lock_in      (lock_in),
        .ctrl_rd      (ctrl_rd),
        .out_en       (out_en),
        .lock_timeout (lock_timeout),
        .status       (status)
    );

    // {write data, expected readback}; loop disabled for all of them
    localparam logic [63:0] WR_TAB [8] = '{
        {32'hFFFF_FFFF, 32'h07FF_FFFF},
        {32'h0000_0100, 32'h0000_0000},
        {32'h0000_0200, 32'h0000_0000},
        {32'h0000_0300, 32'h0000_0000},
        {32'h0000_0400, 32'h0000_0400},
        {32'h0000_0710, 32'h0000_0710},
        {32'hF800_0000, 32'h0000_0000},
        {32'h0000_0B13, 32'h0000_0813}
    };

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    function automatic logic [7:0] st_word(int st, bit lk, bit fl, bit oe);
        return {2'b00, oe, fl, lk, 3'(st)};
    endfunction

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic write_reg(input logic [31:0] d);
        wr_en = 1'b1;
        wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        tick_us = 1'b1;
        repeat (n) step();
        tick_us = 1'b0;
    endtask

    task automatic start_loop();
        loop_en = 1'b1;
        step();
        startup_done = 1'b1;
        step();
        startup_done = 1'b0;
    endtask

    task automatic stop_and_clear();
        loop_en = 1'b0;
        to_clr = 1'b1;
        step();
        to_clr = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got 0x0 expected 0x1");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        #1;
        // R1 reset state, R13 encoding
        chk("R1 ctrl", ctrl_rd, 32'h0000_0020);
        chk("R1 out_en", {31'd0, out_en}, 32'd0);
        chk("R1 flag", {31'd0, lock_timeout}, 32'd0);
        rst_n = 1'b1;
        step();
        chk("R13 status idle", {24'd0, status}, 32'h0);

        // R2 / R4 table walk
        for (int i = 0; i < 8; i++) begin
            write_reg(WR_TAB[i][63:32]);
            chk("R2 R4 readback", ctrl_rd, WR_TAB[i][31:0]);
        end

        // R5 startup, R3 write lock, R8 code 4 time-out
        write_reg(32'h0000_0400);
        loop_en = 1'b1;
        step();
        chk("R5 startup state", {24'd0, status}, {24'd0, st_word(1, 0, 0, 0)});
        write_reg(32'hFFFF_FFFF);
        chk("R3 write ignored", ctrl_rd, 32'h0000_0400);
        startup_done = 1'b1;
        step();
        startup_done = 1'b0;
        chk("R5 wait state", {24'd0, status}, {24'd0, st_word(2, 0, 0, 0)});
        ticks(799);
        chk("R8 before limit", {24'd0, status}, {24'd0, st_word(2, 0, 0, 0)});
        ticks(1);
        chk("R8 timeout", {24'd0, status}, {24'd0, st_word(4, 0, 1, 0)});
        ticks(50);
        chk("R8 timeout held", {24'd0, status}, {24'd0, st_word(4, 0, 1, 0)});
        loop_en = 1'b0;
        step();
        chk("R11 idle after disable", {24'd0, status}, {24'd0, st_word(0, 0, 1, 0)});
        step();
        chk("R10 flag sticky", {31'd0, lock_timeout}, 32'd1);
        to_clr = 1'b1;
        step();
        to_clr = 1'b0;
        chk("R10 flag cleared", {31'd0, lock_timeout}, 32'd0);

        // R8 codes 5..7
        for (int c = 5; c < 8; c++) begin
            int lim;
            lim = 800 + 100 * (c - 4);
            write_reg(32'(c) << 8);
            start_loop();
            ticks(lim - 1);
            chk("R8 below limit", {29'd0, status[2:0]}, 32'd2);
            ticks(1);
            chk("R8 limit reached", {24'd0, status}, {24'd0, st_word(4, 0, 1, 0)});
            stop_and_clear();
        end

        // R9 restart of count on each wait entry
        write_reg(32'h0000_0400);
        start_loop();
        ticks(500);
        loop_en = 1'b0;
        step();
        start_loop();
        ticks(799);
        chk("R9 count restarted", {24'd0, status}, {24'd0, st_word(2, 0, 0, 0)});
        lock_in = 1'b1;
        step();
        chk("R5 run on lock", {24'd0, status}, {24'd0, st_word(3, 1, 0, 1)});
        loop_en = 1'b0;
        step();
        chk("R11 gate drops", {31'd0, out_en}, 32'd0);
        lock_in = 1'b0;

        // R7 code 0 never times out
        write_reg(32'h0000_0000);
        start_loop();
        ticks(1200);
        chk("R7 no timeout", {24'd0, status}, {24'd0, st_word(2, 0, 0, 0)});
        lock_in = 1'b1;
        step();
        chk("R7 lock after long wait", {31'd0, out_en}, 32'd1);
        lock_in = 1'b0;
        loop_en = 1'b0;
        step();

        // R6 fast wake
        write_reg(32'h0000_0410);
        start_loop();
        chk("R6 released without lock", {24'd0, status}, {24'd0, st_word(3, 0, 0, 1)});
        ticks(900);
        chk("R6 stays released", {31'd0, out_en}, 32'd1);
        loop_en = 1'b0;
        step();

        // R12 lock bypass
        write_reg(32'h0000_0C00);
        loop_en = 1'b1;
        step();
        chk("R12 bypass lock", {31'd0, status[3]}, 32'd1);
        startup_done = 1'b1;
        step();
        startup_done = 1'b0;
        step();
        chk("R12 run via bypass", {24'd0, status}, {24'd0, st_word(3, 1, 0, 1)});
        loop_en = 1'b0;
        step();

        // R10 set wins over clear
        write_reg(32'h0000_0400);
        start_loop();
        ticks(799);
        to_clr = 1'b1;
        ticks(1);
        to_clr = 1'b0;
        chk("R10 set beats clear", {31'd0, lock_timeout}, 32'd1);
        stop_and_clear();
        chk("R10 cleared at end", {31'd0, lock_timeout}, 32'd0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule